// File: doc/BRIEF.md
# Serial Programming Command Sequencer

This block is the host side of a two-wire in-circuit programming link. It drives a programming clock, a data line that it can release, and an active-low reset line to the target device. An upstream controller hands it one command at a time over a valid/ready port. The commands are: enter programming mode, execute an instruction, read the target's output register, and flush. For a read, the 16-bit result comes back on a one-cycle response strobe.

Each bit is framed the same way. Data is set up as the programming clock rises and is held while the clock is high. The target samples it on the falling edge. The half-period is a programmable number of system clocks, so a bring-up can run the link slowly. The target runs each instruction word while the next control code is being shifted in. For that reason a flush command exists, which shifts a bare 4-clock code so that the last instruction executes.

After the target leaves reset, it always treats the first command as an execute command with three extra code clocks. The block tracks this with a pending flag. The flag is set by reset and by every entry sequence, and it is cleared once the stretched command has been sent.

Top module: `prog_seq`

## Requirements
- R1: After reset: tgt_rst_no is 0, prog_clk_o is 0, prog_dat_oe_o is 1, prog_dat_o is 0, cmd_ready_o is 1 and rsp_valid_o is 0.
- R2: For every bit, prog_clk_o is high for exactly cfg_div_i+1 system clocks and then low for at least cfg_div_i+1. prog_dat_o and prog_dat_oe_o change only on the rising edge of prog_clk_o.
- R3: The enter command (cmd_op_i=3) drives tgt_rst_no to 0 and waits cfg_gap_i+1 cycles. It then shifts the 32-bit key 0xA5C30F96 most significant bit first with tgt_rst_no still low. tgt_rst_no rises one system clock after the falling edge of the last key bit. The sequence then waits cfg_gap_i+1 cycles before the block goes ready.
- R4: The first command after reset or after an enter is stretched. If it is an execute (cmd_op_i=0), the block sends 7 zero code clocks and then the 24-bit cmd_word_i, least significant bit first.
- R5: Any other execute command sends the code 0000 (4 clocks) followed by the 24 word bits, least significant bit first.
- R6: The read command (cmd_op_i=1) has four phases:
  - It sends the code 0001, least significant bit first (bits 1,0,0,0).
  - It then sends 8 driven zero clocks.
  - It then releases the data line (prog_dat_oe_o=0) for 16 clocks and samples prog_dat_i on each falling edge, least significant bit first.
  - When the last low phase ends, it pulses rsp_valid_o for one cycle with the 16-bit value.
- R7: The flush command (cmd_op_i=2) sends only the 4-clock code 0000.
- R8: A read or flush issued while the first-command flag is pending is preceded by 31 zero clocks. These 31 clocks are a stretched execute carrying a zero word. After them, the command's normal frame follows.
- R9: Commands are accepted only while cmd_ready_o is high. cmd_ready_o is low for the whole of any frame or entry sequence. cmd_valid_i asserted while the block is busy produces no programming clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_div_i | input | DIV_W | Programming clock half-period minus one, in system clocks |
| cfg_gap_i | input | GAP_W | Clock-low delay around the entry key, in system clocks minus one |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_op_i | input | 2 | 0 execute, 1 read, 2 flush, 3 enter |
| cmd_word_i | input | 24 | Instruction word for execute |
| rsp_valid_o | output | 1 | One-cycle read result strobe |
| rsp_data_o | output | 16 | Read result |
| prog_clk_o | output | 1 | Programming clock to target |
| prog_dat_o | output | 1 | Programming data to target |
| prog_dat_oe_o | output | 1 | Data line drive enable (0 = released) |
| prog_dat_i | input | 1 | Data line as seen at the pad |
| tgt_rst_no | output | 1 | Target reset, active low |

## Verification
Every driven bit is due at a falling edge of prog_clk_o. The scoreboard pops one expected bit, with its expected reset-line level, at exactly that edge. The high-phase width is counted on system-clock falling edges and must equal cfg_div_i+1. The reset-line rise is due one system clock after the last key bit's falling edge, and it is checked against a two-sample history of the programming clock. The read result is due in the cycle after the sixteenth released bit's low phase ends, and it is compared when rsp_valid_o is seen at a system-clock falling edge. All sampling happens on falling edges, away from the edges where the design updates.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    OP_EXEC  = 2'd0,
    OP_READ  = 2'd1,
    OP_FLUSH = 2'd2,
    OP_ENTER = 2'd3
  } op_e;

  typedef enum logic [2:0] {ST_IDLE, ST_GAP0, ST_KEY, ST_GAP1, ST_SHIFT} st_e;
  typedef enum logic [2:0] {SEG_PRE, SEG_CODE, SEG_WORD, SEG_PAD, SEG_RD} seg_e;
  typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} ph_e;

  localparam int unsigned CODE_W      = 4;
  localparam int unsigned WORD_W      = 24;
  localparam int unsigned RD_W        = 16;
  localparam int unsigned PAD_N       = 8;
  localparam int unsigned KEY_W       = 32;
  localparam int unsigned FIRST_EXTRA = 3;

  localparam logic [CODE_W-1:0] CODE_EXEC = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_READ = 4'b0001;
endpackage

// File: rtl/prog_tick_gen.sv
module prog_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/prog_bit_phy.sv
module prog_bit_phy
  import prog_seq_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             bit_valid_i,
  input  logic             bit_data_i,
  input  logic             bit_drive_i,
  output logic             bit_ready_o,
  output logic             bit_done_o,
  output logic             fall_o,
  output logic             rx_o,
  output logic             prog_clk_o,
  output logic             prog_dat_o,
  output logic             prog_dat_oe_o,
  input  logic             prog_dat_i
);
  timeunit 1ns;
  timeprecision 1ps;

  ph_e  ph_q;
  logic tick;

  prog_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ph_q != PH_IDLE),
    .div_i  (div_i),
    .tick_o (tick)
  );

  assign bit_ready_o = (ph_q == PH_IDLE);
  assign bit_done_o  = (ph_q == PH_LOW) && tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q          <= PH_IDLE;
      prog_clk_o    <= 1'b0;
      prog_dat_o    <= 1'b0;
      prog_dat_oe_o <= 1'b1;
      fall_o        <= 1'b0;
      rx_o          <= 1'b0;
    end else begin
      fall_o <= 1'b0;
      case (ph_q)
        PH_IDLE: if (bit_valid_i) begin
          ph_q          <= PH_HIGH;
          prog_clk_o    <= 1'b1;
          prog_dat_o    <= bit_drive_i & bit_data_i;
          prog_dat_oe_o <= bit_drive_i;
        end
        PH_HIGH: if (tick) begin
          ph_q       <= PH_LOW;
          prog_clk_o <= 1'b0;
          fall_o     <= 1'b1;
          rx_o       <= prog_dat_i;  // target data valid at our falling edge
        end
        PH_LOW: if (tick) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R2
  pgd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_clk_o && $past(prog_clk_o)) |-> ($stable(prog_dat_o) && $stable(prog_dat_oe_o)));

  // R2
  fall_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!prog_clk_o && $past(prog_clk_o)));
endmodule

// File: rtl/prog_seq_ctrl.sv
module prog_seq_ctrl
  import prog_seq_pkg::*;
#(
  parameter int unsigned       GAP_W = 8,
  parameter logic [KEY_W-1:0]  KEY   = 32'hA5C3_0F96
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GAP_W-1:0]  gap_i,
  input  logic              cmd_valid_i,
  input  op_e               cmd_op_i,
  input  logic [WORD_W-1:0] cmd_word_i,
  output logic              cmd_ready_o,
  output logic              rsp_valid_o,
  output logic [RD_W-1:0]   rsp_data_o,
  output logic              bit_valid_o,
  output logic              bit_data_o,
  output logic              bit_drive_o,
  input  logic              bit_done_i,
  input  logic              fall_i,
  input  logic              rx_i,
  output logic              tgt_rst_no
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CNT_W = $clog2(KEY_W);

  st_e               st_q;
  seg_e              seg_q, seg_nxt;
  logic              seg_end;
  op_e               op_q;
  logic [WORD_W-1:0] word_q;
  logic [KEY_W-1:0]  sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GAP_W-1:0]  gap_q;
  logic              first_pend_q;
  logic [RD_W-1:0]   rd_q, rd_shift;

  function automatic logic [KEY_W-1:0] seg_sh(seg_e s, op_e o, logic [WORD_W-1:0] w);
    case (s)
      SEG_CODE: return KEY_W'((o == OP_READ) ? CODE_READ : CODE_EXEC);
      SEG_WORD: return KEY_W'(w);
      default:  return '0;
    endcase
  endfunction

  // bit count minus one per segment
  function automatic logic [CNT_W-1:0] seg_len(seg_e s, op_e o);
    case (s)
      SEG_PRE:  return (o == OP_EXEC) ? CNT_W'(FIRST_EXTRA - 1)
                                      : CNT_W'(FIRST_EXTRA + CODE_W + WORD_W - 1);
      SEG_CODE: return CNT_W'(CODE_W - 1);
      SEG_WORD: return CNT_W'(WORD_W - 1);
      SEG_PAD:  return CNT_W'(PAD_N - 1);
      default:  return CNT_W'(RD_W - 1);
    endcase
  endfunction

  always_comb begin
    seg_nxt = SEG_CODE;
    seg_end = 1'b0;
    case (seg_q)
      SEG_PRE:  seg_nxt = SEG_CODE;
      SEG_CODE: begin
        if (op_q == OP_EXEC)      seg_nxt = SEG_WORD;
        else if (op_q == OP_READ) seg_nxt = SEG_PAD;
        else                      seg_end = 1'b1;
      end
      SEG_PAD:  seg_nxt = SEG_RD;
      default:  seg_end = 1'b1;
    endcase
  end

  assign rd_shift    = {rx_i, rd_q[RD_W-1:1]};
  assign cmd_ready_o = (st_q == ST_IDLE);
  assign bit_valid_o = (st_q == ST_KEY) || (st_q == ST_SHIFT);
  assign bit_data_o  = (st_q == ST_KEY) ? sh_q[KEY_W-1] : sh_q[0];
  assign bit_drive_o = !((st_q == ST_SHIFT) && (seg_q == SEG_RD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      seg_q        <= SEG_PRE;
      op_q         <= OP_EXEC;
      word_q       <= '0;
      sh_q         <= '0;
      cnt_q        <= '0;
      gap_q        <= '0;
      first_pend_q <= 1'b1;
      tgt_rst_no   <= 1'b0;
      rd_q         <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_data_o   <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          if (cmd_op_i == OP_ENTER) begin
            tgt_rst_no   <= 1'b0;
            first_pend_q <= 1'b1;
            gap_q        <= gap_i;
            st_q         <= ST_GAP0;
          end else begin
            op_q   <= cmd_op_i;
            word_q <= cmd_word_i;
            st_q   <= ST_SHIFT;
            if (first_pend_q) begin
              first_pend_q <= 1'b0;
              seg_q        <= SEG_PRE;
              sh_q         <= '0;
              cnt_q        <= seg_len(SEG_PRE, cmd_op_i);
            end else begin
              seg_q <= SEG_CODE;
              sh_q  <= seg_sh(SEG_CODE, cmd_op_i, cmd_word_i);
              cnt_q <= seg_len(SEG_CODE, cmd_op_i);
            end
          end
        end
        ST_GAP0: begin
          if (gap_q == '0) begin
            st_q  <= ST_KEY;
            sh_q  <= KEY;
            cnt_q <= CNT_W'(KEY_W - 1);
          end else gap_q <= gap_q - 1'b1;
        end
        ST_KEY: begin
          // release target reset right after the last key falling edge
          if (fall_i && cnt_q == '0) tgt_rst_no <= 1'b1;
          if (bit_done_i) begin
            if (cnt_q == '0) begin
              st_q  <= ST_GAP1;
              gap_q <= gap_i;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              sh_q  <= sh_q << 1;
            end
          end
        end
        ST_GAP1: begin
          if (gap_q == '0) st_q <= ST_IDLE;
          else             gap_q <= gap_q - 1'b1;
        end
        ST_SHIFT: if (bit_done_i) begin
          if (seg_q == SEG_RD) rd_q <= rd_shift;
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            sh_q  <= sh_q >> 1;
          end else if (seg_end) begin
            st_q <= ST_IDLE;
            if (seg_q == SEG_RD) begin
              rsp_valid_o <= 1'b1;
              rsp_data_o  <= rd_shift;
            end
          end else begin
            seg_q <= seg_nxt;
            sh_q  <= seg_sh(seg_nxt, op_q, word_q);
            cnt_q <= seg_len(seg_nxt, op_q);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  // R3
  mclr_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_KEY && bit_done_i && cnt_q != '0) |-> !tgt_rst_no);
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int unsigned      DIV_W = 8,
  parameter int unsigned      GAP_W = 8,
  parameter logic [31:0]      KEY   = 32'hA5C3_0F96
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [GAP_W-1:0] cfg_gap_i,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic [23:0]      cmd_word_i,
  output logic             rsp_valid_o,
  output logic [15:0]      rsp_data_o,
  output logic             prog_clk_o,
  output logic             prog_dat_o,
  output logic             prog_dat_oe_o,
  input  logic             prog_dat_i,
  output logic             tgt_rst_no
);
  timeunit 1ns;
  timeprecision 1ps;

  logic bit_valid, bit_data, bit_drive, bit_ready, bit_done, fall, rx;

  prog_seq_ctrl #(.GAP_W(GAP_W), .KEY(KEY)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gap_i       (cfg_gap_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (op_e'(cmd_op_i)),
    .cmd_word_i  (cmd_word_i),
    .cmd_ready_o (cmd_ready_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .bit_valid_o (bit_valid),
    .bit_data_o  (bit_data),
    .bit_drive_o (bit_drive),
    .bit_done_i  (bit_done),
    .fall_i      (fall),
    .rx_i        (rx),
    .tgt_rst_no  (tgt_rst_no)
  );

  prog_bit_phy #(.DIV_W(DIV_W)) u_phy (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .div_i         (cfg_div_i),
    .bit_valid_i   (bit_valid),
    .bit_data_i    (bit_data),
    .bit_drive_i   (bit_drive),
    .bit_ready_o   (bit_ready),
    .bit_done_o    (bit_done),
    .fall_o        (fall),
    .rx_o          (rx),
    .prog_clk_o    (prog_clk_o),
    .prog_dat_o    (prog_dat_o),
    .prog_dat_oe_o (prog_dat_oe_o),
    .prog_dat_i    (prog_dat_i)
  );

  // R9
  ready_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!prog_clk_o && bit_ready));

  // R3
  mclr_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_rst_no) |-> (!prog_clk_o && $past(fall)));
endmodule

// File: tb/prog_seq_tb_top.sv
module prog_seq_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd1;
  logic [7:0]  cfg_gap = 8'd5;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [23:0] cmd_word = '0;
  logic        cmd_ready, rsp_valid, pclk, pdat, pdat_oe, tgt_rst_n;
  logic [15:0] rsp_data;
  logic        pdat_in = 1'b0;

  always #5 clk = ~clk;

  prog_seq dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cfg_div_i (cfg_div), .cfg_gap_i (cfg_gap),
    .cmd_valid_i (cmd_valid), .cmd_ready_o (cmd_ready), .cmd_op_i (cmd_op),
    .cmd_word_i (cmd_word), .rsp_valid_o (rsp_valid), .rsp_data_o (rsp_data),
    .prog_clk_o (pclk), .prog_dat_o (pdat), .prog_dat_oe_o (pdat_oe),
    .prog_dat_i (pdat_in), .tgt_rst_no (tgt_rst_n)
  );

  int          n_chk = 0, n_fail = 0, cur_div = 1, hcnt = 0, ridx = 0;
  bit          pend = 1'b1, ended = 1'b0;
  logic [15:0] tgt_word = '0;
  logic [1:0]  exp_q[$];   // {reset level, data bit}
  string       tag_q[$];
  logic [15:0] rsp_q[$];
  logic        p1 = 1'b0, p2 = 1'b0, m1 = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic push_bits(input logic [31:0] v, input int n, input bit msb_first,
                           input logic rst_lvl, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({rst_lvl, msb_first ? v[n-1-i] : v[i]});
      tag_q.push_back(tag);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [23:0] w, input logic [15:0] rd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    case (op)
      2'd3: begin push_bits(32'hA5C3_0F96, 32, 1'b1, 1'b0, "R3"); pend = 1'b1; end
      2'd0: begin
        if (pend) push_bits(0, 3, 1'b0, 1'b1, "R4");
        push_bits(0, 4, 1'b0, 1'b1, pend ? "R4" : "R5");
        push_bits({8'h0, w}, 24, 1'b0, 1'b1, pend ? "R4" : "R5");
        pend = 1'b0;
      end
      2'd1: begin
        if (pend) push_bits(0, 31, 1'b0, 1'b1, "R8");
        push_bits(32'h1, 4, 1'b0, 1'b1, "R6");
        push_bits(0, 8, 1'b0, 1'b1, "R6");
        rsp_q.push_back(rd);
        tgt_word = rd;
        ridx = 0;
        pend = 1'b0;
      end
      default: begin
        if (pend) push_bits(0, 31, 1'b0, 1'b1, "R8");
        push_bits(0, 4, 1'b0, 1'b1, "R7");
        pend = 1'b0;
      end
    endcase
    cmd_valid = 1'b1; cmd_op = op; cmd_word = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (!cmd_ready || exp_q.size() != 0 || rsp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "leftover bits", exp_q.size(), 0);
  endtask

  // scoreboard monitor: target samples on falling programming clock
  always @(negedge pclk) begin
    if (rst_n && pdat_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected bit", pdat, 0);
      else begin
        logic [1:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({tgt_rst_n, pdat} == e, t, "bit/reset", {tgt_rst_n, pdat}, e);
      end
    end
  end

  // target model drives read data after the rising edge
  always @(posedge pclk) begin
    #1;
    if (!pdat_oe && ridx < 16) begin
      pdat_in = tgt_word[ridx];
      ridx++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pclk) hcnt++;
      else if (hcnt != 0) begin
        chk(hcnt == cur_div + 1, "R2", "high width", hcnt, cur_div + 1);
        hcnt = 0;
      end
      if (!m1 && tgt_rst_n)
        chk(p2 && !p1, "R3", "reset rise vs last fall", {p2, p1}, 2'b10);
      if (rsp_valid) begin
        if (rsp_q.size() == 0) chk(1'b0, "R6", "unexpected response", rsp_data, 0);
        else begin
          logic [15:0] r;
          r = rsp_q.pop_front();
          chk(rsp_data == r, "R6", "read data", rsp_data, r);
        end
      end
      p2 = p1; p1 = pclk; m1 = tgt_rst_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tgt_rst_n == 1'b0, "R1", "reset line", tgt_rst_n, 0);
    chk(pclk == 1'b0, "R1", "prog clock", pclk, 0);
    chk(pdat_oe == 1'b1 && pdat == 1'b0, "R1", "data drive", {pdat_oe, pdat}, 2'b10);
    chk(cmd_ready == 1'b1, "R1", "ready", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "rsp valid", rsp_valid, 0);
    rst_n = 1'b1;

    send(2'd3, 0, 0);
    chk(!cmd_ready, "R9", "busy during entry", cmd_ready, 0);
    wait_done();
    chk(tgt_rst_n == 1'b1, "R3", "reset released", tgt_rst_n, 1);
    send(2'd0, 24'hC3A517, 0);   // R4 stretched first execute
    send(2'd0, 24'h5A0F33, 0);   // R5
    send(2'd1, 0, 16'hB62D);     // R6
    send(2'd2, 0, 0);            // R7
    wait_done();

    // R9 request held during a frame is ignored
    send(2'd0, 24'h0F0F0F, 0);
    cmd_op = 2'd1; cmd_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(!cmd_ready, "R9", "ready while busy", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    wait_done();
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0 && !pclk, "R9", "quiet after ignore", exp_q.size(), 0);

    cur_div = 3; cfg_div = 8'd3; cfg_gap = 8'd2;   // R2 new divider
    send(2'd3, 0, 0);
    send(2'd1, 0, 16'h8001);     // R8 stretched read
    send(2'd0, 24'hFFFFFF, 0);   // R5
    wait_done();
    send(2'd3, 0, 0);
    send(2'd2, 0, 0);            // R8 stretched flush
    send(2'd1, 0, 16'h7E42);     // R6
    wait_done();
    finish_run();
  end
endmodule